// File: doc/BRIEF.md
# Periodic Down-Counter Tick Timer

The block is a periodic tick timer built around a down-counter whose width is set by a parameter (24 bits by default). Software sees three word registers: a control/status word, a reload value, and the live counter value. When the timer is enabled, the counter steps down once for each active tick. A tick comes either from a bus-clock-enable strobe or from an external reference tick, and a control bit chooses which. When the counter reaches zero, the next active tick loads it again from the reload register. One full period is therefore the reload value plus one ticks.

A sticky count flag is set when the counter steps from 1 to 0. When the interrupt is armed, the flag drives the interrupt request. The flag is cleared in two ways: by a pulse on the acknowledge input, or by any write to the current-value register. That write also forces the counter to zero, so counting starts again from the reload value on the next active tick. The register bus writes in a single cycle. Read data is registered.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, the control, reload, counter and flag values are all zero, `irq` is low and `rdata` is zero.
- R2: The registers are addressed by word index: 0 is control, 1 is reload, 2 is current value, and index 3 reads zero. In the control word, bit 0 enables counting and bit 1 arms the interrupt. Bit 2 chooses the tick source: 1 counts on `bus_clk_en`, 0 counts on `ref_tick`. Bit 16 holds the count flag. All other bits read zero.
- R3: On each active tick the counter moves from a nonzero value N to N-1. From zero it loads the reload value. The period is reload+1 ticks.
- R4: The count flag is set only by an active tick taken while the counter holds 1. Once set, it stays set until it is cleared.
- R5: A write to the current-value register, whatever the data, zeroes the counter and clears the flag. It overrides any tick or acknowledge in the same cycle.
- R6: An `irq_ack` pulse clears the flag. If a tick sets the flag in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when both the flag and the arm bit are 1.
- R8: With a reload value of 0, the counter stays at zero once it gets there, and the flag is not set again.
- R9: For the reload and current-value registers, write data bits above CNT_W-1 are ignored, and those bits read back as zero.
- R10: While the timer is disabled, or when the selected source gives no tick, the counter holds its value and the flag is not set.
- R11: `rdata` shows the addressed register as it stood before a clock edge, and appears one cycle after `addr` is presented.
- R12: Writes to control bit 16 do not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| bus_clk_en | input | 1 | Bus-clock tick strobe |
| ref_tick | input | 1 | External reference tick |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with an 8-bit counter and 32-bit data. At that width a full period of 256 ticks can be reached. Random reload values regularly produce wraparounds and 1-to-0 events, and the ignored upper data bits stay a large field. A cycle-level reference model in the bench is run against random mixes of both tick sources, acknowledges and writes to every register. Directed sequences add a zero reload, collisions between a tick and an acknowledge, and current-value writes that land on a tick.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int CTRL_IDX = 0;
  localparam int RELOAD_IDX = 1;
  localparam int CURR_IDX = 2;
  localparam int FLAG_BIT = 16;

  typedef struct packed {
    logic use_bus;
    logic arm;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tt_regs.sv
module tt_regs #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output tt_pkg::ctrl_t     ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_wr
);
  logic wr_ctrl, wr_reload;

  assign wr_ctrl   = wr_en && (addr == ADDR_W'(tt_pkg::CTRL_IDX));
  assign wr_reload = wr_en && (addr == ADDR_W'(tt_pkg::RELOAD_IDX));
  assign cur_wr    = wr_en && (addr == ADDR_W'(tt_pkg::CURR_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.run     <= wdata[0];
        ctrl.arm     <= wdata[1];
        ctrl.use_bus <= wdata[2];
      end
      if (wr_reload) reload <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tt_tick_sel.sv
module tt_tick_sel (
  input  tt_pkg::ctrl_t ctrl,
  input  logic          bus_clk_en,
  input  logic          ref_tick,
  output logic          tick
);
  always_comb begin
    tick = ctrl.run && (ctrl.use_bus ? bus_clk_en : ref_tick);
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cur_wr,
  input  logic             ack,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cur_wr) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ack) flag_q <= 1'b0;
      if (tick) begin
        if (cnt_q == '0) begin
          cnt_q <= reload;
        end else begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) flag_q <= 1'b1;
        end
      end
    end
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cur_wr && cnt_q == ONE) |=> flag_q);
  // R5
  cur_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cur_wr |=> (cnt_q == '0 && !flag_q));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cur_wr) |=> $stable(cnt_q));
  // R8
  zero_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cur_wr && !ack && cnt_q == '0 && reload == '0) |=> (cnt_q == '0 && $stable(flag_q)));
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !cur_wr && !(tick && cnt_q == ONE)) |=> !flag_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              bus_clk_en,
  input  logic              ref_tick,
  input  logic              irq_ack,
  output logic              irq
);
  tt_pkg::ctrl_t    ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             cur_wr, tick, flag;

  tt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl(ctrl), .reload(reload), .cur_wr(cur_wr)
  );

  tt_tick_sel u_sel (
    .ctrl(ctrl), .bus_clk_en(bus_clk_en), .ref_tick(ref_tick), .tick(tick)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cur_wr(cur_wr), .ack(irq_ack),
    .reload(reload), .cnt_q(cnt), .flag_q(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        ADDR_W'(tt_pkg::CTRL_IDX): begin
          rdata[0] <= ctrl.run;
          rdata[1] <= ctrl.arm;
          rdata[2] <= ctrl.use_bus;
          rdata[tt_pkg::FLAG_BIT] <= flag;
        end
        ADDR_W'(tt_pkg::RELOAD_IDX): rdata[CNT_W-1:0] <= reload;
        ADDR_W'(tt_pkg::CURR_IDX):   rdata[CNT_W-1:0] <= cnt;
        default: rdata <= '0;
      endcase
    end
  end

  assign irq = flag && ctrl.arm;

  // R7
  irq_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(tt_pkg::CTRL_IDX) && !wdata[1]) |=> !irq);
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bus_clk_en = 1'b0;
  logic        ref_tick = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic          m_run = 0, m_arm = 0, m_bus = 0, m_flag = 0;
  logic [CW-1:0] m_reload = '0, m_cnt = '0;
  logic [31:0]   m_rdata = '0;

  tick_timer #(.CNT_W(CW), .DATA_W(32), .ADDR_W(2)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bus_clk_en(bus_clk_en), .ref_tick(ref_tick),
    .irq_ack(irq_ack), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: begin v[0] = m_run; v[1] = m_arm; v[2] = m_bus; v[16] = m_flag; end
      2'd1: v[CW-1:0] = m_reload;
      2'd2: v[CW-1:0] = m_cnt;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic w, input logic [1:0] a, input logic [31:0] d,
                            input logic bce, input logic rt, input logic ak);
    logic tk;
    logic [CW-1:0] ncnt;
    logic nflag;
    m_rdata = model_read(a);
    tk = m_run && (m_bus ? bce : rt);
    ncnt = m_cnt;
    nflag = m_flag;
    if (w && a == 2'd2) begin
      ncnt = '0; nflag = 1'b0;
    end else begin
      if (ak) nflag = 1'b0;
      if (tk) begin
        if (m_cnt == '0) ncnt = m_reload;
        else begin
          ncnt = m_cnt - 1'b1;
          if (m_cnt == CW'(1)) nflag = 1'b1;
        end
      end
    end
    m_cnt = ncnt;
    m_flag = nflag;
    if (w && a == 2'd0) begin m_run = d[0]; m_arm = d[1]; m_bus = d[2]; end
    if (w && a == 2'd1) m_reload = d[CW-1:0];
  endtask

  task automatic step(input string tag, input logic w, input logic [1:0] a,
                      input logic [31:0] d, input logic bce, input logic rt,
                      input logic ak);
    wr_en = w; addr = a; wdata = d; bus_clk_en = bce; ref_tick = rt; irq_ack = ak;
    @(posedge clk);
    model_edge(w, a, d, bce, rt, ak);
    @(negedge clk);
    check({tag, " rdata"}, rdata, m_rdata);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_flag && m_arm});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    step("R1 ctrl", 0, 2'd0, 0, 0, 0, 0);
    step("R1 reload", 0, 2'd1, 0, 0, 0, 0);
    step("R1 count", 0, 2'd2, 0, 0, 0, 0);
    // R9 upper data bits dropped
    step("R9 write reload", 1, 2'd1, 32'hABCD_EF03, 0, 0, 0);
    step("R9 read reload", 0, 2'd1, 0, 0, 0, 0);
    // R12 bit16 write ignored; R2 enable/arm/bus source
    step("R12 write ctrl", 1, 2'd0, 32'h0001_0007, 0, 0, 0);
    step("R12 read ctrl", 0, 2'd0, 0, 0, 0, 0);
    // R3 R4 R7 sequence 3,2,1,0 and flag
    for (int i = 0; i < 10; i++) step("R3 R4 R7 count", 0, (i % 2) ? 2'd2 : 2'd0, 0, 1, 0, 0);
    // R6 ack clears
    step("R6 ack", 0, 2'd0, 0, 0, 0, 1);
    step("R6 after ack", 0, 2'd0, 0, 0, 0, 0);
    // R6 ack colliding with setting tick
    while (m_cnt != CW'(1)) step("R3 run to one", 0, 2'd2, 0, 1, 0, 0);
    step("R6 ack with set", 0, 2'd0, 0, 1, 0, 1);
    step("R6 flag kept", 0, 2'd0, 0, 0, 0, 0);
    // R5 current write on a tick
    step("R5 clear write", 1, 2'd2, 32'hFFFF_FFFF, 1, 0, 0);
    step("R5 read count", 0, 2'd2, 0, 0, 0, 0);
    step("R5 read flag", 0, 2'd0, 0, 0, 0, 0);
    // R10 disabled holds
    step("R10 reload first", 0, 2'd2, 0, 1, 0, 0);
    step("R10 disable", 1, 2'd0, 32'h2, 0, 0, 0);
    for (int i = 0; i < 6; i++) step("R10 hold", 0, 2'd2, 0, 1, 1, 0);
    // R2 ref tick source: bus strobe has no effect
    step("R2 ref src", 1, 2'd0, 32'h3, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R2 bus ignored", 0, 2'd2, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) step("R2 ref counts", 0, 2'd2, 0, 0, 1, 0);
    step("R2 index3", 0, 2'd3, 0, 0, 0, 0);
    // R8 zero reload
    step("R8 reload zero", 1, 2'd1, 32'h0, 0, 0, 0);
    step("R8 clear", 1, 2'd2, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) step("R8 stay zero", 0, (i % 2) ? 2'd2 : 2'd0, 0, 0, 1, 0);
    // R11 random mix against model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] d = $urandom;
      logic w = (r[3:0] == 4'd0);
      if (w && r[5:4] == 2'd0) d[0] = 1'b1;
      step("R11 random", w, r[7:6], d, r[8] | r[9], r[10] | r[11], r[15:12] == 4'd0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule